// File: doc/BRIEF.md
# Interrupt Entry and Return Controller

This block is the control slice a small CPU core uses to enter interrupt handlers and to come back from them. It watches one non-maskable request line and a set of maskable request lines, keeps the state that each kind of event needs saved (the interrupted PC and PSW, one pair per event class), and owns the live PSW and the cause register. The core reports each instruction boundary together with the PC it is about to execute, and pulses a return strobe when it retires a return-from-interrupt instruction. The block answers with a one-cycle redirect carrying the address the core must fetch next.

Requests are remembered as pulses until they are accepted. Events are considered only at instruction boundaries. A return strobe in the same cycle takes precedence and leaves any boundary event pending. The PSW is always copied to its save register with the value it held before entry, and only then are the mask bits changed. A return picks its save pair from the EP and NP bits of the live PSW. After reset the ID bit is set, so maskable lines stay blocked until the core executes a return that restores a PSW with ID clear.

Top module: `intr_ctl`

## Requirements
- R1: While `rst` is high, every clock edge sets `redir_vld` to 1, `redir_pc` to 0, `psw` to 0x20 and `ecr` to 0, and it clears all pending requests and both save pairs; requests raised before reset are not delivered after it.
- R2: A non-maskable entry saves the boundary PC and the current PSW in the fatal pair, sets `ecr` to {16'h0000, old ecr[15:0] | 16'h0010}, sets NP (PSW bit 7) and ID (PSW bit 5), clears EP (PSW bit 6) and redirects to 0x10; ID does not block it.
- R3: A non-maskable request seen while NP is set is not taken; at most one such request is remembered (further ones are dropped) and it is taken at the first boundary after NP clears.
- R4: A maskable request is not taken at a boundary while NP or ID is set; it stays pending until a boundary where both are clear.
- R5: Maskable entry saves the boundary PC and the PSW value from before entry in the interrupt pair, then sets ID and clears EP.
- R6: Maskable entry writes the source code into `ecr[15:0]` and leaves `ecr[31:16]` unchanged.
- R7: Maskable line i (bit i of `irq_req`, i = 0..5) vectors to 0x80 + 0x10*i, and its cause code equals that address.
- R8: On a return strobe, if EP is set the PC and PSW come from the interrupt pair; else if NP is set they come from the fatal pair; else from the interrupt pair.
- R9: The return target is the saved PC with bit 0 cleared, with no instruction-length adjustment.
- R10: When a non-maskable and a maskable request are both pending at a boundary, the non-maskable one is taken and the maskable one stays pending.
- R11: When several maskable lines are pending, the lowest line number is taken and the others stay pending.
- R12: `redir_vld` is a one-cycle pulse in the cycle after an accepted event or return; it is 0 after any cycle with neither a boundary nor a return; a return in the same cycle as a boundary wins and the boundary event stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_req | input | 1 | Non-maskable request pulse |
| irq_req | input | NUM_SRC | Maskable request pulses, one per line |
| bnd_vld | input | 1 | Instruction boundary strobe |
| bnd_pc | input | AW | PC of the next instruction at the boundary |
| ret_vld | input | 1 | Return-from-interrupt strobe |
| redir_vld | output | 1 | Redirect pulse |
| redir_pc | output | AW | Redirect target address |
| psw | output | DW | Live processor status word |
| ecr | output | DW | Live cause register |

## Verification
The bench builds the block with its default values: six maskable lines, 32-bit PC and status words, vectors starting at 0x80 with a 0x10 stride, and the non-maskable vector at 0x10. Six lines reach every vector, including the lowest and the highest, and a 32-bit cause register lets the bench see that a non-maskable entry clears the upper half while a maskable entry keeps it. The bench walks nested entries (a non-maskable event inside a maskable handler) so that both return branches are reached, and it drives request bursts while NP is set to show that exactly one waiting request survives.

// File: rtl/intr_ctl_pkg.sv
`timescale 1ns/1ps
package intr_ctl_pkg;
  // PSW bit positions decoded by the core and by this block
  localparam int PSW_ID = 5;  // maskable lines disabled
  localparam int PSW_EP = 6;  // exception in progress
  localparam int PSW_NP = 7;  // non-maskable event in service

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/intr_pend.sv
`timescale 1ns/1ps
module intr_pend #(
  parameter int NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               nmi_req,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic               nmi_take,
  input  logic [NUM_SRC-1:0] irq_clr,
  output logic               nmi_eff,
  output logic [NUM_SRC-1:0] irq_eff
);
  logic               nmi_q;
  logic [NUM_SRC-1:0] irq_q;

  // a request is visible in the cycle it arrives
  assign nmi_eff = nmi_q | nmi_req;
  assign irq_eff = irq_q | irq_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_q <= 1'b0;
      irq_q <= '0;
    end else begin
      // single slot: extra non-maskable pulses collapse into one
      nmi_q <= nmi_eff & ~nmi_take;
      irq_q <= irq_eff & ~irq_clr;
    end
  end
endmodule

// File: rtl/intr_arb.sv
`timescale 1ns/1ps
module intr_arb #(
  parameter int NUM_SRC = 6,
  localparam int IDX_W = intr_ctl_pkg::idx_width(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx,
  output logic [NUM_SRC-1:0] gnt
);
  logic [NUM_SRC:0] below;

  assign below[0] = 1'b0;
  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
      assign gnt[i]       = req[i] & ~below[i];
      assign below[i + 1] = below[i] | req[i];
    end
  endgenerate

  assign any = below[NUM_SRC];

  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (gnt[i]) idx = IDX_W'(i);
  end
endmodule

// File: rtl/intr_ctx.sv
`timescale 1ns/1ps
module intr_ctx
  import intr_ctl_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          save_irq,
  input  logic          save_nmi,
  input  logic [AW-1:0] cur_pc,
  input  logic [DW-1:0] cur_psw,
  output logic [AW-1:0] ret_pc,
  output logic [DW-1:0] ret_psw
);
  logic [AW-1:0] ipc_q, fpc_q;
  logic [DW-1:0] ipsw_q, fpsw_q;
  logic [AW-1:0] sel_pc;

  // cur_psw is the pre-entry value: the mask update lands on the same edge
  always_ff @(posedge clk) begin
    if (rst) begin
      ipc_q  <= '0;
      ipsw_q <= '0;
      fpc_q  <= '0;
      fpsw_q <= '0;
    end else begin
      if (save_irq) begin
        ipc_q  <= cur_pc;
        ipsw_q <= cur_psw;
      end
      if (save_nmi) begin
        fpc_q  <= cur_pc;
        fpsw_q <= cur_psw;
      end
    end
  end

  always_comb begin
    if (cur_psw[PSW_EP]) begin
      sel_pc  = ipc_q;
      ret_psw = ipsw_q;
    end else if (cur_psw[PSW_NP]) begin
      sel_pc  = fpc_q;
      ret_psw = fpsw_q;
    end else begin
      sel_pc  = ipc_q;
      ret_psw = ipsw_q;
    end
  end

  assign ret_pc = {sel_pc[AW-1:1], 1'b0};
endmodule

// File: rtl/intr_ctl.sv
`timescale 1ns/1ps
module intr_ctl
  import intr_ctl_pkg::*;
#(
  parameter int          NUM_SRC   = 6,
  parameter int          AW        = 32,
  parameter int          DW        = 32,
  parameter logic [31:0] VEC_BASE  = 32'h80,
  parameter logic [31:0] VEC_STEP  = 32'h10,
  parameter logic [31:0] NMI_VEC   = 32'h10,
  parameter logic [31:0] NMI_CODE  = 32'h10,
  parameter logic [31:0] RESET_PSW = 32'h20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               nmi_req,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic               bnd_vld,
  input  logic [AW-1:0]      bnd_pc,
  input  logic               ret_vld,
  output logic               redir_vld,
  output logic [AW-1:0]      redir_pc,
  output logic [DW-1:0]      psw,
  output logic [DW-1:0]      ecr
);
  localparam int IDX_W = idx_width(NUM_SRC);
  localparam int HW    = DW / 2;

  logic               nmi_eff;
  logic [NUM_SRC-1:0] irq_eff;
  logic               arb_any;
  logic [IDX_W-1:0]   arb_idx;
  logic [NUM_SRC-1:0] arb_gnt;
  logic               take_ret, take_nmi, take_irq;
  logic [AW-1:0]      ctx_pc;
  logic [DW-1:0]      ctx_psw;
  logic [AW-1:0]      vec_addr;
  logic [DW-1:0]      nmi_psw, irq_psw;

  logic               rv_q;
  logic [AW-1:0]      rpc_q;
  logic [DW-1:0]      psw_q, ecr_q;

  // precedence: return, then non-maskable, then maskable
  assign take_ret = ret_vld;
  assign take_nmi = !ret_vld && bnd_vld && nmi_eff && !psw_q[PSW_NP];
  assign take_irq = !ret_vld && bnd_vld && !take_nmi && arb_any &&
                    !psw_q[PSW_NP] && !psw_q[PSW_ID];

  intr_pend #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .nmi_req  (nmi_req),
    .irq_req  (irq_req),
    .nmi_take (take_nmi),
    .irq_clr  (take_irq ? arb_gnt : '0),
    .nmi_eff  (nmi_eff),
    .irq_eff  (irq_eff)
  );

  intr_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .req (irq_eff),
    .any (arb_any),
    .idx (arb_idx),
    .gnt (arb_gnt)
  );

  intr_ctx #(.AW(AW), .DW(DW)) u_ctx (
    .clk      (clk),
    .rst      (rst),
    .save_irq (take_irq),
    .save_nmi (take_nmi),
    .cur_pc   (bnd_pc),
    .cur_psw  (psw_q),
    .ret_pc   (ctx_pc),
    .ret_psw  (ctx_psw)
  );

  assign vec_addr = AW'(VEC_BASE) + AW'(arb_idx) * AW'(VEC_STEP);

  always_comb begin
    nmi_psw         = psw_q;
    nmi_psw[PSW_NP] = 1'b1;
    nmi_psw[PSW_ID] = 1'b1;
    nmi_psw[PSW_EP] = 1'b0;
    irq_psw         = psw_q;
    irq_psw[PSW_ID] = 1'b1;
    irq_psw[PSW_EP] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rv_q  <= 1'b1;
      rpc_q <= '0;
      psw_q <= DW'(RESET_PSW);
      ecr_q <= '0;
    end else begin
      rv_q <= 1'b0;
      if (take_ret) begin
        rv_q  <= 1'b1;
        rpc_q <= ctx_pc;
        psw_q <= ctx_psw;
      end else if (take_nmi) begin
        rv_q  <= 1'b1;
        rpc_q <= AW'(NMI_VEC);
        psw_q <= nmi_psw;
        ecr_q <= {{(DW-HW){1'b0}}, ecr_q[HW-1:0] | HW'(NMI_CODE)};
      end else if (take_irq) begin
        rv_q  <= 1'b1;
        rpc_q <= vec_addr;
        psw_q <= irq_psw;
        ecr_q <= {ecr_q[DW-1:HW], HW'(vec_addr)};
      end
    end
  end

  assign redir_vld = rv_q;
  assign redir_pc  = rpc_q;
  assign psw       = psw_q;
  assign ecr       = ecr_q;
endmodule

// File: rtl/intr_ctl_chk.sv
`timescale 1ns/1ps
module intr_ctl_chk
  import intr_ctl_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int          DW        = 32,
  parameter logic [31:0] NMI_VEC   = 32'h10,
  parameter logic [31:0] RESET_PSW = 32'h20
) (
  input logic          clk,
  input logic          rst,
  input logic          nmi_req,
  input logic          bnd_vld,
  input logic          ret_vld,
  input logic          redir_vld,
  input logic [AW-1:0] redir_pc,
  input logic [DW-1:0] psw,
  input logic [DW-1:0] ecr
);
  localparam int HW = DW / 2;

  logic rst_seen = 1'b0;

  always_ff @(posedge clk) begin
    if (rst_seen) begin
      assert_reset_state_R1: assert (redir_vld && redir_pc == '0 &&
                                     psw == DW'(RESET_PSW) && ecr == '0)
        else $error("reset state wrong");
    end
    rst_seen <= rst;
  end

  assert_nmi_entry_R2: assert property (@(posedge clk) disable iff (rst)
    (bnd_vld && !ret_vld && nmi_req && !psw[PSW_NP]) |=>
      (redir_vld && redir_pc == AW'(NMI_VEC) && psw[PSW_NP] && psw[PSW_ID] &&
       !psw[PSW_EP] && ecr[DW-1:HW] == '0));

  assert_nmi_held_R3: assert property (@(posedge clk) disable iff (rst)
    (bnd_vld && !ret_vld && psw[PSW_NP]) |=> !redir_vld);

  assert_masked_R4: assert property (@(posedge clk) disable iff (rst)
    (bnd_vld && !ret_vld && psw[PSW_ID]) |=>
      (!redir_vld || redir_pc == AW'(NMI_VEC)));

  assert_ret_even_R9: assert property (@(posedge clk) disable iff (rst)
    ret_vld |=> (redir_vld && !redir_pc[0]));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    (!bnd_vld && !ret_vld) |=> !redir_vld);
endmodule

bind intr_ctl intr_ctl_chk #(
  .AW(AW), .DW(DW), .NMI_VEC(NMI_VEC), .RESET_PSW(RESET_PSW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .nmi_req   (nmi_req),
  .bnd_vld   (bnd_vld),
  .ret_vld   (ret_vld),
  .redir_vld (redir_vld),
  .redir_pc  (redir_pc),
  .psw       (psw),
  .ecr       (ecr)
);

// File: tb/intr_ctl_tb_top.sv
`timescale 1ns/1ps
module intr_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        nmi_req = 1'b0;
  logic [5:0]  irq_req = '0;
  logic        bnd_vld = 1'b0;
  logic [31:0] bnd_pc = '0;
  logic        ret_vld = 1'b0;
  logic        redir_vld;
  logic [31:0] redir_pc, psw, ecr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  intr_ctl dut_i (
    .clk(clk), .rst(rst), .nmi_req(nmi_req), .irq_req(irq_req),
    .bnd_vld(bnd_vld), .bnd_pc(bnd_pc), .ret_vld(ret_vld),
    .redir_vld(redir_vld), .redir_pc(redir_pc), .psw(psw), .ecr(ecr)
  );

  // ---------------- behavioural reference ----------------
  bit          m_on = 0;
  bit          m_rv, m_np;
  logic [31:0] m_rpc, m_psw, m_ecr, m_ipc, m_ipsw, m_fpc, m_fpsw;
  logic [5:0]  m_ip;

  always @(posedge clk) begin
    bit          n_eff, took_n;
    logic [5:0]  i_eff;
    int          pick;
    m_on = 1;
    if (rst) begin
      m_rv = 1; m_rpc = 0; m_psw = 32'h20; m_ecr = 0;
      m_ipc = 0; m_ipsw = 0; m_fpc = 0; m_fpsw = 0; m_np = 0; m_ip = 0;
    end else begin
      n_eff = m_np | nmi_req;
      i_eff = m_ip | irq_req;
      took_n = 0;
      pick = -1;
      m_rv = 0;
      if (ret_vld) begin
        m_rv = 1;
        if (m_psw[6])      begin m_rpc = m_ipc & ~32'h1; m_psw = m_ipsw; end
        else if (m_psw[7]) begin m_rpc = m_fpc & ~32'h1; m_psw = m_fpsw; end
        else               begin m_rpc = m_ipc & ~32'h1; m_psw = m_ipsw; end
      end else if (bnd_vld && n_eff && !m_psw[7]) begin
        took_n = 1; m_rv = 1; m_fpc = bnd_pc; m_fpsw = m_psw;
        m_psw = (m_psw | 32'hA0) & ~32'h40;
        m_ecr = {16'h0, m_ecr[15:0] | 16'h10};
        m_rpc = 32'h10;
      end else if (bnd_vld && i_eff != 0 && !m_psw[7] && !m_psw[5]) begin
        for (int k = 5; k >= 0; k--) if (i_eff[k]) pick = k;
        m_rv = 1; m_ipc = bnd_pc; m_ipsw = m_psw;
        m_psw = (m_psw | 32'h20) & ~32'h40;
        m_rpc = 32'h80 + 32'h10 * pick;
        m_ecr = {m_ecr[31:16], m_rpc[15:0]};
      end
      m_np = n_eff & ~took_n;
      if (pick >= 0) i_eff[pick] = 1'b0;
      m_ip = i_eff;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare against the reference every cycle, away from the active edge
  always @(negedge clk) begin
    if (m_on) begin
      chk("R12 model redir_vld", {31'h0, redir_vld}, {31'h0, m_rv});
      if (m_rv) chk("R8 model redir_pc", redir_pc, m_rpc);
      chk("R5 model psw", psw, m_psw);
      chk("R6 model ecr", ecr, m_ecr);
    end
  end

  // drive one cycle of stimulus, return at the next falling edge
  task automatic cyc(input bit b, input logic [31:0] pc, input bit r,
                     input bit n, input logic [5:0] irq);
    bnd_vld = b; bnd_pc = pc; ret_vld = r; nmi_req = n; irq_req = irq;
    @(negedge clk);
    bnd_vld = 0; ret_vld = 0; nmi_req = 0; irq_req = '0;
  endtask

  task automatic expect_redir(input string tag, input logic [31:0] pc);
    chk({tag, " vld"}, {31'h0, redir_vld}, 32'h1);
    chk({tag, " pc"}, redir_pc, pc);
  endtask

  task automatic expect_none(input string tag);
    chk(tag, {31'h0, redir_vld}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, checks=%0d expected completion", checks);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    // R1 reset state
    expect_redir("R1 reset", 32'h0);
    chk("R1 reset psw", psw, 32'h20);
    chk("R1 reset ecr", ecr, 32'h0);
    rst = 0;
    @(negedge clk);
    expect_none("R12 pulse ends after reset");

    cyc(1, 32'h100, 0, 0, 6'b000001);
    expect_none("R4 blocked by ID");
    cyc(0, 0, 1, 0, 0);
    expect_redir("R8 return plain", 32'h0);
    chk("R8 psw restored", psw, 32'h0);
    cyc(1, 32'h200, 0, 0, 0);
    expect_redir("R4 pending taken later", 32'h80);
    chk("R6 ecr code", ecr, 32'h80);
    chk("R5 psw masked", psw, 32'h20);
    cyc(1, 32'h204, 0, 0, 6'b010100);
    expect_none("R4 blocked in handler");

    cyc(1, 32'h305, 0, 1, 0);
    expect_redir("R2 nmi entry", 32'h10);
    chk("R2 nmi psw", psw, 32'hA0);
    chk("R2 nmi ecr", ecr, 32'h90);
    cyc(1, 32'h10, 0, 1, 0);
    expect_none("R3 nmi held");
    cyc(1, 32'h14, 0, 1, 0);
    expect_none("R3 second nmi held");
    cyc(0, 0, 1, 0, 0);
    expect_redir("R9 fatal return even", 32'h304);
    chk("R8 fatal psw", psw, 32'h20);
    cyc(1, 32'h400, 0, 0, 0);
    expect_redir("R3 remembered nmi", 32'h10);
    cyc(0, 0, 1, 0, 0);
    expect_redir("R8 fatal return", 32'h400);
    cyc(1, 32'h404, 0, 0, 0);
    expect_none("R3 extra nmi dropped");
    cyc(0, 0, 1, 0, 0);
    expect_redir("R8 irq pair return", 32'h200);
    chk("R5 saved pre-entry psw", psw, 32'h0);

    cyc(1, 32'h208, 0, 0, 0);
    expect_redir("R11 lowest line", 32'hA0);
    chk("R6 ecr lower", ecr, 32'hA0);
    cyc(0, 0, 1, 0, 0);
    cyc(1, 32'h20C, 0, 0, 0);
    expect_redir("R11 other line kept", 32'hC0);
    cyc(0, 0, 1, 0, 0);
    expect_redir("R9 return to saved pc", 32'h20C);

    for (int i = 0; i < 6; i++) begin
      cyc(1, 32'h600 + 4 * i, 0, 0, 6'(1 << i));
      expect_redir("R7 vector", 32'h80 + 32'h10 * i);
      chk("R7 code", ecr, 32'h80 + 32'h10 * i);
      cyc(0, 0, 1, 0, 0);
      expect_redir("R9 loop return", 32'h600 + 4 * i);
    end

    cyc(1, 32'h700, 0, 1, 6'b000010);
    expect_redir("R10 nmi first", 32'h10);
    chk("R10 ecr", ecr, 32'hD0);
    cyc(0, 0, 1, 0, 0);
    expect_redir("R10 back", 32'h700);
    cyc(1, 32'h704, 0, 0, 0);
    expect_redir("R10 irq kept", 32'h90);
    cyc(0, 0, 1, 0, 0);

    cyc(1, 32'h800, 1, 0, 6'b001000);
    expect_redir("R12 return wins", 32'h704);
    @(negedge clk);
    expect_none("R12 single pulse");
    cyc(1, 32'h804, 0, 0, 0);
    expect_redir("R12 deferred boundary", 32'hB0);
    cyc(0, 0, 1, 0, 0);

    cyc(0, 0, 0, 1, 6'b100000);
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    @(negedge clk);
    cyc(0, 0, 1, 0, 0);
    chk("R1 psw after return", psw, 32'h0);
    cyc(1, 32'h900, 0, 0, 0);
    expect_none("R1 pending cleared");

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule